// File: doc/BRIEF.md
# Single-Bus Hardwired Control Sequencer

This block is a small processor core. Every register-to-register move goes over one shared internal bus, and each clock cycle carries one word. The core holds a program counter, a memory address register, a memory data register, an instruction register, an ALU operand latch Y, an ALU result latch Z, a flag N and a sixteen-entry register file. A hardwired controller turns a step counter, the opcode and the N flag into per-step gating signals. The gating signals choose at most one bus driver, the registers that load from the bus, the ALU operand select and the memory read or write.

Each instruction runs as a fixed list of steps, T1 to T7. The first three steps fetch the instruction and add 4 to the program counter. The remaining steps depend on the opcode. In a step that waits for memory, the step counter holds until the memory raises its done input. The step that asserts the end signal sends the counter back to T1 on the next clock. Memory sees a word-aligned byte address, a read or write level, and the write data. Each request stays up until done.

Instruction word: opcode in bits 31:24, register field A in bits 23:20, register field B in bits 19:16, signed 16-bit offset in bits 15:0. Opcodes: 8'h01 add-from-memory, 8'h02 load, 8'h03 store, 8'h04 branch, 8'h05 branch-if-negative. Every other code is a no-operation.

Step sequences (state names T1..T7, `step_no` = index - 1):
- T1→T2→T3 (fetch).
- Add-from-memory: T4→T5→T6→T7→T1.
- Load: T4→T5→T6→T1.
- Store: T4→T5→T6→T1.
- Branch: T4→T5→T1.
- Branch-if-negative: T4→T1 when N=0, or T4→T5→T1 when N=1.
- No-operation: T4→T1.
- T2 holds while memory is not done. So does T5 of add and load, and T6 of store.

Top module: `sbus_core`

## Requirements
- R1: While reset is held, `step_no` is 0 (T1), `pc_now` is 0, and neither `mem_rd` nor `mem_wr` is high.
- R2: In T1 the core raises `mem_rd` with `mem_addr` equal to the program counter. When T2 completes, `pc_now` has grown by 4, and T3 loads the returned word into the instruction register.
- R3: In a waiting step (T2; T5 of add and load; T6 of store), while `mem_done` is low, `step_no`, `pc_now` and any pending request stay unchanged.
- R4: Add-from-memory (8'h01) sets register A to register A plus the word at the address held in register B, and sets N to bit 31 of the sum. It ends in T7.
- R5: Load (8'h02) sets register A to the word at the address held in register B. It ends in T6.
- R6: Store (8'h03) raises `mem_wr` with `mem_addr` equal to register B and `mem_wdata` equal to register A. Address and data stay stable until `mem_done`. Read and write are never high together.
- R7: Branch (8'h04) sets the program counter to the fetched PC+4 plus the sign-extended offset. It ends in T5.
- R8: Branch-if-negative (8'h05) behaves as R7 when N=1. When N=0 it ends in T4 and leaves the program counter at PC+4.
- R9: Any other opcode ends in T4 and changes no register or memory word.
- R10: After a step that asserts `instr_end` and is not waiting, the next step is T1. At most one source drives the internal bus in any step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | AW | Byte address from the memory address register |
| mem_rd | output | 1 | Read request level, held until done |
| mem_wr | output | 1 | Write request level, held until done |
| mem_wdata | output | DW | Write data from the memory data register |
| mem_rdata | input | DW | Read data, captured when done arrives during a read |
| mem_done | input | 1 | Memory function complete |
| step_no | output | 3 | Current step, 0 for T1 to 6 for T7 |
| pc_now | output | DW | Program counter |
| instr_end | output | 1 | End signal of the current step |

## Verification
The bench builds the core with its defaults: DW=32, AW=16, NREG=16. This gives the full 32-bit instruction layout, so a sign-extended negative offset, an add that overflows into bit 31 and sets N, and all sixteen register fields are reachable. The bench memory answers after 0 to 3 cycles, rotating per request. This covers both a done that arrives in the first waiting cycle and one that comes several cycles late. The program walks a taken and a not-taken negative branch, a forward jump over a store, a backward loop and a no-operation code.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    localparam int OPC_LSB = 24;
    localparam int RA_LSB  = 20;
    localparam int RB_LSB  = 16;
    localparam int OFF_W   = 16;

    localparam logic [7:0] OP_ADDM  = 8'h01;
    localparam logic [7:0] OP_LOAD  = 8'h02;
    localparam logic [7:0] OP_STORE = 8'h03;
    localparam logic [7:0] OP_BR    = 8'h04;
    localparam logic [7:0] OP_BRN   = 8'h05;

    typedef enum logic [2:0] {
        T1 = 3'd0,
        T2 = 3'd1,
        T3 = 3'd2,
        T4 = 3'd3,
        T5 = 3'd4,
        T6 = 3'd5,
        T7 = 3'd6
    } step_e;

    // gating word produced by the step decoder
    typedef struct packed {
        logic pc_o;
        logic mdr_o;
        logic z_o;
        logic ra_o;
        logic rb_o;
        logic off_o;
        logic pc_i;
        logic mar_i;
        logic mdr_i;
        logic ir_i;
        logic y_i;
        logic z_i;
        logic ra_i;
        logic sel4;
        logic rd;
        logic wr;
        logic wmfc;
        logic setn;
        logic fin;
    } ctl_t;

endpackage

// File: rtl/sbus_step.sv
module sbus_step
    import sbus_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  go,
    input  logic  fin,
    output step_e step
);

    step_e step_q;
    step_e step_d;

    always_comb begin
        step_d = step_q;
        if (go) begin
            if (fin) begin
                step_d = T1;
            end else begin
                unique case (step_q)
                    T1:      step_d = T2;
                    T2:      step_d = T3;
                    T3:      step_d = T4;
                    T4:      step_d = T5;
                    T5:      step_d = T6;
                    T6:      step_d = T7;
                    T7:      step_d = T1;
                    default: step_d = T1;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= T1;
        end else begin
            step_q <= step_d;
        end
    end

    assign step = step_q;

endmodule

// File: rtl/sbus_decode.sv
module sbus_decode
    import sbus_pkg::*;
(
    input  step_e      step,
    input  logic [7:0] opcode,
    input  logic       n_flag,
    output ctl_t       ctl
);

    always_comb begin
        ctl = '0;
        unique case (step)
            T1: begin
                ctl.pc_o  = 1'b1;
                ctl.mar_i = 1'b1;
                ctl.rd    = 1'b1;
                ctl.sel4  = 1'b1;
                ctl.z_i   = 1'b1;
            end
            T2: begin
                ctl.z_o  = 1'b1;
                ctl.pc_i = 1'b1;
                ctl.y_i  = 1'b1;
                ctl.wmfc = 1'b1;
            end
            T3: begin
                ctl.mdr_o = 1'b1;
                ctl.ir_i  = 1'b1;
            end
            T4: begin
                unique case (opcode)
                    OP_ADDM, OP_LOAD: begin
                        ctl.rb_o  = 1'b1;
                        ctl.mar_i = 1'b1;
                        ctl.rd    = 1'b1;
                    end
                    OP_STORE: begin
                        ctl.rb_o  = 1'b1;
                        ctl.mar_i = 1'b1;
                    end
                    OP_BR: begin
                        ctl.off_o = 1'b1;
                        ctl.z_i   = 1'b1;
                    end
                    OP_BRN: begin
                        ctl.off_o = 1'b1;
                        ctl.z_i   = 1'b1;
                        ctl.fin   = !n_flag;
                    end
                    default: ctl.fin = 1'b1;
                endcase
            end
            T5: begin
                unique case (opcode)
                    OP_ADDM: begin
                        ctl.ra_o = 1'b1;
                        ctl.y_i  = 1'b1;
                        ctl.wmfc = 1'b1;
                    end
                    OP_LOAD: ctl.wmfc = 1'b1;
                    OP_STORE: begin
                        ctl.ra_o  = 1'b1;
                        ctl.mdr_i = 1'b1;
                        ctl.wr    = 1'b1;
                    end
                    OP_BR, OP_BRN: begin
                        ctl.z_o  = 1'b1;
                        ctl.pc_i = 1'b1;
                        ctl.fin  = 1'b1;
                    end
                    default: ctl.fin = 1'b1;
                endcase
            end
            T6: begin
                unique case (opcode)
                    OP_ADDM: begin
                        ctl.mdr_o = 1'b1;
                        ctl.z_i   = 1'b1;
                        ctl.setn  = 1'b1;
                    end
                    OP_LOAD: begin
                        ctl.mdr_o = 1'b1;
                        ctl.ra_i  = 1'b1;
                        ctl.fin   = 1'b1;
                    end
                    OP_STORE: begin
                        ctl.wmfc = 1'b1;
                        ctl.fin  = 1'b1;
                    end
                    default: ctl.fin = 1'b1;
                endcase
            end
            T7: begin
                if (opcode == OP_ADDM) begin
                    ctl.z_o  = 1'b1;
                    ctl.ra_i = 1'b1;
                end
                ctl.fin = 1'b1;
            end
            default: ctl.fin = 1'b1;
        endcase
    end

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 16,
    parameter int NREG = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          ctl,
    input  logic [5:0]    drv,
    input  logic          go,
    input  logic          mem_done,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] pc,
    output logic [7:0]    opcode,
    output logic          n_flag
);

    localparam int RIW = $clog2(NREG);

    logic [DW-1:0] mar_q, mdr_q, ir_q, y_q, z_q, pc_q;
    logic [DW-1:0] rf [NREG];
    logic [DW-1:0] bus, alu_a, sum, off_ext;
    logic [RIW-1:0] ra_idx, rb_idx;
    logic          rd_pend, wr_pend, n_q;

    assign ra_idx  = ir_q[RA_LSB +: RIW];
    assign rb_idx  = ir_q[RB_LSB +: RIW];
    assign off_ext = {{(DW-OFF_W){ir_q[OFF_W-1]}}, ir_q[OFF_W-1:0]};

    // single shared bus: drv = {pc, mdr, z, ra, rb, off}; idle bus reads 0
    always_comb begin
        if (drv[5])      bus = pc_q;
        else if (drv[4]) bus = mdr_q;
        else if (drv[3]) bus = z_q;
        else if (drv[2]) bus = rf[ra_idx];
        else if (drv[1]) bus = rf[rb_idx];
        else if (drv[0]) bus = off_ext;
        else             bus = '0;
    end

    assign alu_a = ctl.sel4 ? DW'(4) : y_q;
    assign sum   = alu_a + bus;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            mar_q <= '0;
            ir_q  <= '0;
            y_q   <= '0;
            z_q   <= '0;
            n_q   <= 1'b0;
        end else if (go) begin
            if (ctl.pc_i)  pc_q  <= bus;
            if (ctl.mar_i) mar_q <= bus;
            if (ctl.ir_i)  ir_q  <= bus;
            if (ctl.y_i)   y_q   <= bus;
            if (ctl.z_i)   z_q   <= sum;
            if (ctl.setn)  n_q   <= sum[DW-1];
        end
    end

    // MDR: internal bus load has priority over the external return path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdr_q <= '0;
        end else if (ctl.mdr_i && go) begin
            mdr_q <= bus;
        end else if (rd_pend && mem_done) begin
            mdr_q <= mem_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
        end else begin
            if (rd_pend && mem_done)   rd_pend <= 1'b0;
            else if (ctl.rd && go)     rd_pend <= 1'b1;
            if (wr_pend && mem_done)   wr_pend <= 1'b0;
            else if (ctl.wr && go)     wr_pend <= 1'b1;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_rf
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rf[g] <= '0;
            end else if (go && ctl.ra_i && (ra_idx == RIW'(g))) begin
                rf[g] <= bus;
            end
        end
    end

    assign mem_addr  = mar_q[AW-1:0];
    assign mem_rd    = rd_pend;
    assign mem_wr    = wr_pend;
    assign mem_wdata = mdr_q;
    assign pc        = pc_q;
    assign opcode    = ir_q[OPC_LSB +: 8];
    assign n_flag    = n_q;

endmodule

// File: rtl/sbus_core.sv
module sbus_core
    import sbus_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 16,
    parameter int NREG = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_done,
    output logic [2:0]    step_no,
    output logic [DW-1:0] pc_now,
    output logic          instr_end
);

    step_e      step;
    ctl_t       ctl;
    logic [7:0] opcode;
    logic       n_flag;
    logic       ctl_wmfc;
    logic       go;
    logic [5:0] drv_vec;

    assign ctl_wmfc = ctl.wmfc;
    assign go       = !(ctl_wmfc && !mem_done);
    assign drv_vec  = {ctl.pc_o, ctl.mdr_o, ctl.z_o, ctl.ra_o, ctl.rb_o, ctl.off_o};

    sbus_step u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .fin   (ctl.fin),
        .step  (step)
    );

    sbus_decode u_dec (
        .step   (step),
        .opcode (opcode),
        .n_flag (n_flag),
        .ctl    (ctl)
    );

    sbus_datapath #(
        .DW   (DW),
        .AW   (AW),
        .NREG (NREG)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .drv       (drv_vec),
        .go        (go),
        .mem_done  (mem_done),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .pc        (pc_now),
        .opcode    (opcode),
        .n_flag    (n_flag)
    );

    assign step_no   = step;
    assign instr_end = ctl.fin;

endmodule

// File: rtl/sbus_core_chk.sv
module sbus_core_chk #(
    parameter int DW = 32,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    step_no,
    input logic [DW-1:0] pc_now,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_done,
    input logic          instr_end,
    input logic          wmfc,
    input logic [5:0]    drv
);

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv)); // R10

    AST_END_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_end && !(wmfc && !mem_done)) |=> (step_no == 3'd0)); // R10

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step_no <= 3'd6); // R10

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wmfc && !mem_done) |=> ($stable(step_no) && $stable(pc_now))); // R3

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_no == 3'd1 && mem_done) |=> (pc_now == $past(pc_now) + DW'(4))); // R2

    AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R6

    AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_done) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata))); // R6

endmodule

bind sbus_core sbus_core_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_no   (step_no),
    .pc_now    (pc_now),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_done  (mem_done),
    .instr_end (instr_end),
    .wmfc      (ctl_wmfc),
    .drv       (drv_vec)
);

// File: tb/sbus_core_bench.sv
`timescale 1ns/1ps
module sbus_core_bench;

    localparam int DW = 32;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_done = 1'b0;
    logic [2:0]    step_no;
    logic [DW-1:0] pc_now;
    logic          instr_end;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sbus_core #(.DW(DW), .AW(AW), .NREG(16)) u_sbus_core (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_done(mem_done), .step_no(step_no), .pc_now(pc_now),
        .instr_end(instr_end)
    );

    // ---------------- bench memory ----------------
    logic [31:0] mem [256];
    int mcnt = 0;
    int mlat = 0;
    int mreq = 0;

    // ---------------- behavioural reference ----------------
    logic [31:0] m_r [16];
    logic [31:0] m_pc, m_mar, m_mdr, m_ir, m_y, m_z;
    logic        m_n, m_rp, m_wp;
    int          m_step;
    bit          m_prev_end;

    function automatic bit ref_end(int s, logic [7:0] op, logic n);
        if (s <= 3) return 0;
        case (op)
            8'h01: return s == 7;
            8'h02: return s == 6;
            8'h03: return s == 6;
            8'h04: return s == 5;
            8'h05: return (s == 4) ? !n : (s == 5);
            default: return s == 4;
        endcase
    endfunction

    function automatic bit ref_wait(int s, logic [7:0] op);
        if (s == 2) return 1;
        if (s == 5 && (op == 8'h01 || op == 8'h02)) return 1;
        if (s == 6 && op == 8'h03) return 1;
        return 0;
    endfunction

    function automatic string tag(int s, logic [7:0] op, bit prev_end, bit waiting);
        if (prev_end) return "R10";
        if (waiting)  return "R3";
        if (s <= 3)   return "R2";
        case (op)
            8'h01: return "R4";
            8'h02: return "R5";
            8'h03: return "R6";
            8'h04: return "R7";
            8'h05: return "R8";
            default: return "R9";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_r[i] = '0;
            m_pc = '0; m_mar = '0; m_mdr = '0; m_ir = '0; m_y = '0; m_z = '0;
            m_n = 0; m_rp = 0; m_wp = 0; m_step = 1; m_prev_end = 0;
        end else begin
            logic [7:0]  op;
            logic [3:0]  ra, rb;
            logic [31:0] off;
            bit          go, fin;
            op  = m_ir[31:24];
            ra  = m_ir[23:20];
            rb  = m_ir[19:16];
            off = {{16{m_ir[15]}}, m_ir[15:0]};
            go  = !(ref_wait(m_step, op) && !mem_done);
            fin = ref_end(m_step, op, m_n);
            if (m_rp && mem_done) begin m_mdr = mem_rdata; m_rp = 0; end
            if (m_wp && mem_done) m_wp = 0;
            if (go) begin
                case (m_step)
                    1: begin m_mar = m_pc; m_z = m_pc + 4; m_rp = 1; end
                    2: begin m_pc = m_z; m_y = m_z; end
                    3: m_ir = m_mdr;
                    default: begin
                        if (op == 8'h01) begin
                            if (m_step == 4) begin m_mar = m_r[rb]; m_rp = 1; end
                            if (m_step == 5) m_y = m_r[ra];
                            if (m_step == 6) begin m_z = m_y + m_mdr; m_n = m_z[31]; end
                            if (m_step == 7) m_r[ra] = m_z;
                        end else if (op == 8'h02) begin
                            if (m_step == 4) begin m_mar = m_r[rb]; m_rp = 1; end
                            if (m_step == 6) m_r[ra] = m_mdr;
                        end else if (op == 8'h03) begin
                            if (m_step == 4) m_mar = m_r[rb];
                            if (m_step == 5) begin m_mdr = m_r[ra]; m_wp = 1; end
                        end else if (op == 8'h04 || op == 8'h05) begin
                            if (m_step == 4) m_z = m_y + off;
                            if (m_step == 5) m_pc = m_z;
                        end
                    end
                endcase
                m_prev_end = fin;
                m_step = fin ? 1 : m_step + 1;
            end else begin
                m_prev_end = 0;
            end
        end
    end

    // compare every cycle at the falling edge, then update memory response
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [7:0] op;
            bit bad;
            op = m_ir[31:24];
            bad = (step_no != 3'(m_step - 1)) || (pc_now != m_pc) ||
                  (mem_rd != m_rp) || (mem_wr != m_wp) ||
                  (instr_end != ref_end(m_step, op, m_n)) ||
                  ((m_rp || m_wp) && (mem_addr != m_mar[AW-1:0])) ||
                  (m_wp && (mem_wdata != m_mdr));
            checks++;
            if (bad) begin
                fails++;
                $display("FAIL %s: step=%0d pc=%h rd=%b wr=%b addr=%h wd=%h end=%b expected step=%0d pc=%h rd=%b wr=%b addr=%h wd=%h end=%b",
                    tag(m_step, op, m_prev_end, ref_wait(m_step, op) && m_step != 1),
                    step_no, pc_now, mem_rd, mem_wr, mem_addr, mem_wdata, instr_end,
                    m_step - 1, m_pc, m_rp, m_wp, m_mar[AW-1:0], m_mdr,
                    ref_end(m_step, op, m_n));
            end
        end
        if (mem_rd || mem_wr) begin
            if (mcnt >= mlat) begin
                mem_done = 1'b1;
                if (mem_rd) mem_rdata = mem[mem_addr[9:2]];
                if (mem_wr) mem[mem_addr[9:2]] = mem_wdata;
            end else begin
                mem_done = 1'b0;
            end
            mcnt++;
        end else begin
            mem_done = 1'b0;
            if (mcnt != 0) begin
                mreq++;
                mlat = mreq % 4;
            end
            mcnt = 0;
        end
    end

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[0]  = 32'h0000_0200; // unknown opcode, field doubles as pointer
        mem[1]  = 32'h0210_0000; // load  R1,(R0)
        mem[2]  = 32'h0221_0000; // load  R2,(R1)
        mem[3]  = 32'h0232_0000; // load  R3,(R2)
        mem[4]  = 32'h0132_0000; // addm  R3,(R2)  -> negative
        mem[5]  = 32'h0331_0000; // store R3,(R1)
        mem[6]  = 32'h0500_0008; // brn +8 taken
        mem[7]  = 32'h0132_0000; // skipped
        mem[8]  = 32'h0132_0000; // skipped
        mem[9]  = 32'h0142_0000; // addm  R4,(R2)  -> positive
        mem[10] = 32'h0500_0008; // brn not taken
        mem[11] = 32'h0330_0000; // store R3,(R0)
        mem[12] = 32'h0400_0004; // br +4
        mem[13] = 32'h0340_0000; // skipped
        mem[14] = 32'h0400_FFFC; // br -4 (self loop)
        mem[128] = 32'h0000_0204;
        mem[129] = 32'h7FFF_FFF0;

        repeat (2) @(negedge clk);
        check("R1", {29'd0, step_no}, 32'd0);
        check("R1", pc_now, 32'd0);
        check("R1", {30'd0, mem_rd, mem_wr}, 32'd0);
        rst_n = 1'b1;

        repeat (700) @(negedge clk);
        check("R6", mem[128], 32'hFFFF_FFE0);       // R4 sum stored
        check("R8", mem[0], 32'hFFFF_FFE0);         // skipped words left R3 alone
        check("R9", mem[129], 32'h7FFF_FFF0);
        check("R7", {31'd0, (pc_now == 32'h38) || (pc_now == 32'h3C)}, 32'd1);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule